// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block rewrites addresses crossing between a local interconnect and a PCIe bus. It holds four translation regions for each direction. An outbound region claims a window of local addresses. It turns each hit into a bus address and reports the transaction type the region carries: memory, I/O, or one of the two configuration types. An inbound region claims every access that lands on one BAR number. It moves such an access onto a 64-bit local target, adding the offset within that BAR.

Software reaches all region fields through a single window. It first writes a viewport word that names a direction and a region index. Field accesses at the fixed offsets that follow then go to that region. The lookup port is combinational. It takes a direction, an address or BAR offset, and a BAR number. It returns a hit flag, the translated address, the type and the winning region index.

Top module: `xlat_window_unit`

## Requirements
- R1: A write to offset 0x900 stores bit 31 as the direction (1 selects inbound, 0 selects outbound) and bits 1:0 as the region index. A read of 0x900 returns exactly those bits, with every other bit zero.
- R2: The field offsets are 0x904 (type, bits 4:0), 0x908 (enable at bit 31, BAR-match at bit 30, BAR number at bits 10:8), 0x90C (base low), 0x910 (base high), 0x914 (limit), 0x918 (target low) and 0x91C (target high). Each access goes to the region and direction that the viewport selects. Bits other than the listed ones read as zero. Writing one direction's region leaves the other direction's region with the same index unchanged.
- R3: After reset, every field of every region reads zero and no lookup hits.
- R4: An enabled outbound region hits when the high address word equals its base high and the low word lies between base low and limit. A hit returns target + (address − base) and the region's type.
- R5: The low bound and the high bound of an outbound window are both inclusive: base and limit hit, while base−1 and limit+1 miss.
- R6: When several regions of the looked-up direction hit, the lowest index wins and its index is reported.
- R7: On a miss, hit is low, the address comes out unchanged and the type reads zero.
- R8: An inbound region hits only when it is enabled, has BAR-match set, and its BAR number equals the looked-up BAR. It returns its 64-bit target plus the offset. An enabled inbound region without BAR-match never hits.
- R9: For a configuration region (type 4 or 5), bits 31:16 of the target low word carry bus (31:24), device (23:19) and function (18:16). These bits come out unchanged for offsets below 64 KiB, and the type is reported as programmed.
- R10: Read data appears one clock after the read is issued and holds until the next read.
- R11: A field write takes effect for lookups starting in the clock cycle after the write.
- R12: Writes to offsets outside 0x900–0x91C change no state, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regEn | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| lkInbound | input | 1 | Lookup direction, 1 = inbound |
| lkAddr | input | 64 | Local address (outbound) or BAR offset (inbound) |
| lkBar | input | 3 | BAR number for inbound lookups |
| lkHit | output | 1 | A region claimed the lookup |
| lkAddrOut | output | 64 | Translated address, or the input address on a miss |
| lkType | output | 5 | Type of the winning region |
| lkRegion | output | 2 | Index of the winning region |

## Verification
A bad viewport latch sends a field to the wrong region. This shows at the ports on the next lookup or readback, as a translation from a neighbouring region or a stray hit in the other direction. Off-by-one window compares show only at the exact boundaries, so the base and limit addresses and their neighbours are probed directly. A wrong priority order shows only when windows overlap. Random windows therefore overlap often, and every result is compared with a bench model of all four outbound regions. Because the lookup is combinational, any corrupted register is visible in the first cycle after the write that caused it.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int IDX_W = $clog2(NUM_REGIONS);
  localparam int TYPE_W = 5;
  localparam int BAR_W = 3;
  localparam int OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_VIEWPORT = 12'h900;
  localparam logic [OFS_W-1:0] OFS_CTL1 = 12'h904;
  localparam logic [OFS_W-1:0] OFS_CTL2 = 12'h908;
  localparam logic [OFS_W-1:0] OFS_BASE_LO = 12'h90C;
  localparam logic [OFS_W-1:0] OFS_BASE_HI = 12'h910;
  localparam logic [OFS_W-1:0] OFS_LIMIT = 12'h914;
  localparam logic [OFS_W-1:0] OFS_TGT_LO = 12'h918;
  localparam logic [OFS_W-1:0] OFS_TGT_HI = 12'h91C;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_CTL1, FLD_CTL2, FLD_BASE_LO,
    FLD_BASE_HI, FLD_LIMIT, FLD_TGT_LO, FLD_TGT_HI
  } fieldSel_e;

  typedef struct packed {
    logic wrEn;
    fieldSel_e field;
    logic selInbound;
    logic [IDX_W-1:0] selIdx;
  } fieldStrobe_t;
endpackage

// File: rtl/xlat_regctl.sv
module xlat_regctl
  import xlat_pkg::*;
#(
  parameter int ADDR_W = OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic [31:0]       fieldRd,
  output fieldStrobe_t      strobe,
  output logic [31:0]       regRdata
);
  logic vpInbound;
  logic [IDX_W-1:0] vpIdx;
  fieldSel_e fieldDec;
  logic isViewport;

  always_comb begin
    case (regAddr)
      ADDR_W'(OFS_CTL1):    fieldDec = FLD_CTL1;
      ADDR_W'(OFS_CTL2):    fieldDec = FLD_CTL2;
      ADDR_W'(OFS_BASE_LO): fieldDec = FLD_BASE_LO;
      ADDR_W'(OFS_BASE_HI): fieldDec = FLD_BASE_HI;
      ADDR_W'(OFS_LIMIT):   fieldDec = FLD_LIMIT;
      ADDR_W'(OFS_TGT_LO):  fieldDec = FLD_TGT_LO;
      ADDR_W'(OFS_TGT_HI):  fieldDec = FLD_TGT_HI;
      default:              fieldDec = FLD_NONE;
    endcase
  end

  assign isViewport = (regAddr == ADDR_W'(OFS_VIEWPORT));

  always_comb begin
    strobe.wrEn = regEn && regWr && (fieldDec != FLD_NONE);
    strobe.field = fieldDec;
    strobe.selInbound = vpInbound;
    strobe.selIdx = vpIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpInbound <= 1'b0;
      vpIdx <= '0;
    end else if (regEn && regWr && isViewport) begin
      vpInbound <= regWdata[31];
      vpIdx <= regWdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (regEn && !regWr)
      regRdata <= isViewport ? {vpInbound, {(31-IDX_W){1'b0}}, vpIdx} : fieldRd;
  end
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int REGIONS = NUM_REGIONS,
  parameter int TW = TYPE_W,
  parameter int BW = BAR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  fieldStrobe_t       strobe,
  input  logic [31:0]        regWdata,
  output logic [31:0]        fieldRd,
  input  logic               lkInbound,
  input  logic [63:0]        lkAddr,
  input  logic [BW-1:0]      lkBar,
  output logic               lkHit,
  output logic [63:0]        lkAddrOut,
  output logic [TW-1:0]      lkType,
  output logic [IDX_W-1:0]   lkRegion
);
  logic [TW-1:0] typeQ   [2][REGIONS];
  logic          enQ     [2][REGIONS];
  logic          barModeQ[2][REGIONS];
  logic [BW-1:0] barQ    [2][REGIONS];
  logic [31:0]   baseLoQ [2][REGIONS];
  logic [31:0]   baseHiQ [2][REGIONS];
  logic [31:0]   limitQ  [2][REGIONS];
  logic [31:0]   tgtLoQ  [2][REGIONS];
  logic [31:0]   tgtHiQ  [2][REGIONS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < REGIONS; r++) begin
          typeQ[d][r] <= '0;
          enQ[d][r] <= 1'b0;
          barModeQ[d][r] <= 1'b0;
          barQ[d][r] <= '0;
          baseLoQ[d][r] <= '0;
          baseHiQ[d][r] <= '0;
          limitQ[d][r] <= '0;
          tgtLoQ[d][r] <= '0;
          tgtHiQ[d][r] <= '0;
        end
      end
    end else if (strobe.wrEn) begin
      case (strobe.field)
        FLD_CTL1: typeQ[strobe.selInbound][strobe.selIdx] <= regWdata[TW-1:0];
        FLD_CTL2: begin
          enQ[strobe.selInbound][strobe.selIdx] <= regWdata[31];
          barModeQ[strobe.selInbound][strobe.selIdx] <= regWdata[30];
          barQ[strobe.selInbound][strobe.selIdx] <= regWdata[8 +: BW];
        end
        FLD_BASE_LO: baseLoQ[strobe.selInbound][strobe.selIdx] <= regWdata;
        FLD_BASE_HI: baseHiQ[strobe.selInbound][strobe.selIdx] <= regWdata;
        FLD_LIMIT:   limitQ[strobe.selInbound][strobe.selIdx] <= regWdata;
        FLD_TGT_LO:  tgtLoQ[strobe.selInbound][strobe.selIdx] <= regWdata;
        FLD_TGT_HI:  tgtHiQ[strobe.selInbound][strobe.selIdx] <= regWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (strobe.field)
      FLD_CTL1: fieldRd = {{(32-TW){1'b0}}, typeQ[strobe.selInbound][strobe.selIdx]};
      FLD_CTL2: fieldRd = {enQ[strobe.selInbound][strobe.selIdx],
                           barModeQ[strobe.selInbound][strobe.selIdx],
                           {(22-BW){1'b0}},
                           barQ[strobe.selInbound][strobe.selIdx], 8'h00};
      FLD_BASE_LO: fieldRd = baseLoQ[strobe.selInbound][strobe.selIdx];
      FLD_BASE_HI: fieldRd = baseHiQ[strobe.selInbound][strobe.selIdx];
      FLD_LIMIT:   fieldRd = limitQ[strobe.selInbound][strobe.selIdx];
      FLD_TGT_LO:  fieldRd = tgtLoQ[strobe.selInbound][strobe.selIdx];
      FLD_TGT_HI:  fieldRd = tgtHiQ[strobe.selInbound][strobe.selIdx];
      default:     fieldRd = '0;
    endcase
  end

  logic [REGIONS-1:0] outMatch, inMatch, anyMatch;
  for (genvar r = 0; r < REGIONS; r++) begin : g_match
    assign outMatch[r] = enQ[0][r] && (baseHiQ[0][r] == lkAddr[63:32]) &&
                         (lkAddr[31:0] >= baseLoQ[0][r]) && (lkAddr[31:0] <= limitQ[0][r]);
    assign inMatch[r] = enQ[1][r] && barModeQ[1][r] && (barQ[1][r] == lkBar);
  end
  assign anyMatch = lkInbound ? inMatch : outMatch;

  logic winFound;
  logic [IDX_W-1:0] winIdx;
  always_comb begin
    winFound = 1'b0;
    winIdx = '0;
    for (int r = REGIONS - 1; r >= 0; r--) begin
      if (anyMatch[r]) begin
        winFound = 1'b1;
        winIdx = IDX_W'(r);
      end
    end
  end

  logic [63:0] winTarget, winOffset;
  always_comb begin
    winTarget = {tgtHiQ[lkInbound][winIdx], tgtLoQ[lkInbound][winIdx]};
    winOffset = lkInbound ? lkAddr : {32'h0, lkAddr[31:0] - baseLoQ[0][winIdx]};
    lkHit = winFound;
    lkRegion = winIdx;
    lkAddrOut = winFound ? winTarget + winOffset : lkAddr;
    lkType = winFound ? typeQ[lkInbound][winIdx] : '0;
  end
endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regEn,
  input  logic        regWr,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        lkInbound,
  input  logic [63:0] lkAddr,
  input  logic [2:0]  lkBar,
  output logic        lkHit,
  output logic [63:0] lkAddrOut,
  output logic [4:0]  lkType,
  output logic [1:0]  lkRegion
);
  fieldStrobe_t strobe;
  logic [31:0] fieldRd;

  xlat_regctl #(.ADDR_W(12)) u_ctl (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .fieldRd(fieldRd), .strobe(strobe), .regRdata(regRdata)
  );

  xlat_datapath #(.REGIONS(NUM_REGIONS), .TW(5), .BW(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata), .fieldRd(fieldRd),
    .lkInbound(lkInbound), .lkAddr(lkAddr), .lkBar(lkBar), .lkHit(lkHit),
    .lkAddrOut(lkAddrOut), .lkType(lkType), .lkRegion(lkRegion)
  );
endmodule

// File: rtl/xlat_window_unit_checker.sv
module xlat_window_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regEn,
  input logic        regWr,
  input logic [11:0] regAddr,
  input logic [31:0] regRdata,
  input logic        lkHit,
  input logic [63:0] lkAddr,
  input logic [63:0] lkAddrOut,
  input logic [4:0]  lkType
);
  assert_viewport_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(regEn && !regWr && regAddr == 12'h900) |-> regRdata[30:2] == '0);

  assert_type_read_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(regEn && !regWr && regAddr == 12'h904) |-> regRdata[31:5] == '0);

  assert_no_hit_after_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !lkHit);

  assert_miss_passthrough_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkAddrOut == lkAddr && lkType == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regEn && !regWr) |-> $stable(regRdata));
endmodule

bind xlat_window_unit xlat_window_unit_checker u_chk (
  .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
  .regRdata(regRdata), .lkHit(lkHit), .lkAddr(lkAddr), .lkAddrOut(lkAddrOut),
  .lkType(lkType)
);

// File: tb/xlat_window_unit_bench.sv
module xlat_window_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regEn = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic lkInbound = 1'b0;
  logic [63:0] lkAddr = '0;
  logic [2:0] lkBar = '0;
  logic lkHit;
  logic [63:0] lkAddrOut;
  logic [4:0] lkType;
  logic [1:0] lkRegion;

  int nChecks = 0;
  int nBad = 0;
  bit done = 0;

  logic [31:0] mBaseLo[4], mBaseHi[4], mLimit[4], mTgtLo[4], mTgtHi[4];
  logic [4:0] mType[4];
  logic mEn[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_window_unit u_xlat_window_unit (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lkInbound(lkInbound), .lkAddr(lkAddr),
    .lkBar(lkBar), .lkHit(lkHit), .lkAddrOut(lkAddrOut), .lkType(lkType), .lkRegion(lkRegion)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 1'b0; regWr = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regEn = 1'b1; regWr = 1'b0; regAddr = a;
    @(negedge clk);
    regEn = 1'b0;
    d = regRdata;
  endtask

  task automatic look(input logic inb, input logic [63:0] a, input logic [2:0] bar);
    lkInbound = inb; lkAddr = a; lkBar = bar;
    #1;
  endtask

  task automatic progOut(input int idx, input logic [31:0] bHi, input logic [31:0] bLo,
                         input logic [31:0] lim, input logic [31:0] tHi, input logic [31:0] tLo,
                         input logic [4:0] ty, input logic en);
    regWrite(12'h900, 32'(idx));
    regWrite(12'h90C, bLo); regWrite(12'h910, bHi); regWrite(12'h914, lim);
    regWrite(12'h918, tLo); regWrite(12'h91C, tHi); regWrite(12'h904, 32'(ty));
    regWrite(12'h908, {en, 31'h0});
    mBaseLo[idx] = bLo; mBaseHi[idx] = bHi; mLimit[idx] = lim;
    mTgtLo[idx] = tLo; mTgtHi[idx] = tHi; mType[idx] = ty; mEn[idx] = en;
  endtask

  task automatic progIn(input int idx, input logic [2:0] bar, input logic [63:0] tgt,
                        input logic [4:0] ty, input logic en, input logic barMode);
    regWrite(12'h900, 32'h8000_0000 | 32'(idx));
    regWrite(12'h918, tgt[31:0]); regWrite(12'h91C, tgt[63:32]);
    regWrite(12'h904, 32'(ty));
    regWrite(12'h908, {en, barMode, 19'h0, bar, 8'h00});
  endtask

  function automatic void expectOut(input logic [63:0] a, output logic h, output logic [63:0] o,
                                    output logic [4:0] t, output logic [1:0] rg);
    h = 1'b0; o = a; t = '0; rg = '0;
    for (int r = 3; r >= 0; r--) begin
      if (mEn[r] && mBaseHi[r] == a[63:32] && a[31:0] >= mBaseLo[r] && a[31:0] <= mLimit[r]) begin
        h = 1'b1; rg = 2'(r); t = mType[r];
        o = {mTgtHi[r], mTgtLo[r]} + {32'h0, a[31:0] - mBaseLo[r]};
      end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic eh;
    logic [63:0] eo;
    logic [4:0] et;
    logic [1:0] er;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      mEn[i] = 0; mBaseLo[i] = 0; mBaseHi[i] = 0; mLimit[i] = 0;
      mTgtLo[i] = 0; mTgtHi[i] = 0; mType[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: reset state
    regRead(12'h900, rd); check("R3 viewport after reset", 64'(rd), 64'h0);
    regRead(12'h908, rd); check("R3 ctl2 after reset", 64'(rd), 64'h0);
    regRead(12'h918, rd); check("R3 target after reset", 64'(rd), 64'h0);
    look(1'b0, 64'h0, 3'd0); check("R3 outbound miss after reset", 64'(lkHit), 64'h0);
    look(1'b1, 64'h10, 3'd0); check("R3 inbound miss after reset", 64'(lkHit), 64'h0);
    look(1'b0, 64'h1234_5678_9ABC_DEF0, 3'd0);
    check("R7 passthrough addr", lkAddrOut, 64'h1234_5678_9ABC_DEF0);
    check("R7 miss type", 64'(lkType), 64'h0);

    // R1: viewport
    regWrite(12'h900, 32'hFFFF_FFFE);
    regRead(12'h900, rd); check("R1 viewport readback", 64'(rd), 64'h8000_0002);

    // R2: field isolation and widths
    regWrite(12'h900, 32'h0000_0002); regWrite(12'h90C, 32'hAAAA_0000);
    regWrite(12'h900, 32'h8000_0002); regWrite(12'h90C, 32'h5555_0000);
    regRead(12'h90C, rd); check("R2 inbound2 base", 64'(rd), 64'h5555_0000);
    regWrite(12'h900, 32'h0000_0002);
    regRead(12'h90C, rd); check("R2 outbound2 base", 64'(rd), 64'hAAAA_0000);
    regWrite(12'h904, 32'hFFFF_FFFF);
    regRead(12'h904, rd); check("R2 type width", 64'(rd), 64'h1F);
    regWrite(12'h908, 32'hFFFF_FFFF);
    regRead(12'h908, rd); check("R2 ctl2 bits", 64'(rd), 64'hC000_0700);

    // R12: unmapped offsets
    regWrite(12'h920, 32'hDEAD_BEEF);
    regWrite(12'h8FC, 32'hDEAD_BEEF);
    regRead(12'h920, rd); check("R12 unmapped read", 64'(rd), 64'h0);
    regRead(12'h90C, rd); check("R12 field untouched", 64'(rd), 64'hAAAA_0000);
    regRead(12'h900, rd); check("R12 viewport untouched", 64'(rd), 64'h2);

    // R10: read data hold
    regRead(12'h90C, rd);
    regWrite(12'h90C, 32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", 64'(regRdata), 64'hAAAA_0000);

    // Directed outbound window
    for (int i = 0; i < 4; i++) progOut(i, 0, 0, 0, 0, 0, 0, 1'b0);
    progOut(1, 32'h1, 32'h1000, 32'h1FFF, 32'h20, 32'h8000_0000, 5'd0, 1'b1);
    look(1'b0, 64'h1_0000_1000, 0);
    check("R11 hit right after program", 64'(lkHit), 64'h1);
    check("R5 base hits addr", lkAddrOut, 64'h20_8000_0000);
    look(1'b0, 64'h1_0000_1FFF, 0);
    check("R5 limit hits", 64'(lkHit), 64'h1);
    check("R4 limit addr", lkAddrOut, 64'h20_8000_0FFF);
    look(1'b0, 64'h1_0000_0FFF, 0); check("R5 base-1 misses", 64'(lkHit), 64'h0);
    look(1'b0, 64'h1_0000_2000, 0); check("R5 limit+1 misses", 64'(lkHit), 64'h0);
    look(1'b0, 64'h2_0000_1800, 0); check("R4 upper mismatch", 64'(lkHit), 64'h0);
    look(1'b0, 64'h1_0000_1234, 0);
    check("R4 mid addr", lkAddrOut, 64'h20_8000_0234);
    check("R4 region", 64'(lkRegion), 64'h1);

    // R6: priority
    progOut(0, 32'h1, 32'h1800, 32'h2FFF, 32'h0, 32'h4000_0000, 5'd2, 1'b1);
    look(1'b0, 64'h1_0000_1900, 0);
    check("R6 lowest wins region", 64'(lkRegion), 64'h0);
    check("R6 lowest wins addr", lkAddrOut, 64'h4000_0100);
    check("R6 lowest wins type", 64'(lkType), 64'h2);
    look(1'b0, 64'h1_0000_17FF, 0);
    check("R6 only region1", 64'(lkRegion), 64'h1);

    // R9: configuration regions
    progOut(2, 32'h2, 32'h0, 32'hFFF, 32'h0, 32'h032A_0000, 5'd4, 1'b1);
    progOut(3, 32'h3, 32'h0, 32'hFFF, 32'h0, 32'hFF_F8_0000 | 32'h7_0000, 5'd5, 1'b1);
    look(1'b0, 64'h2_0000_0044, 0);
    check("R9 cfg0 bus dev func", lkAddrOut, 64'h032A_0044);
    check("R9 cfg0 type", 64'(lkType), 64'h4);
    look(1'b0, 64'h3_0000_0FFC, 0);
    check("R9 cfg1 bus dev func", lkAddrOut, 64'hFFFF_0FFC);
    check("R9 cfg1 type", 64'(lkType), 64'h5);

    // R8: inbound BAR match
    progIn(0, 3'd0, 64'h0000_0000_8000_0000, 5'd0, 1'b1, 1'b1);
    progIn(1, 3'd1, 64'h0000_0000_8000_2000, 5'd0, 1'b1, 1'b1);
    progIn(2, 3'd2, 64'h0000_0000_8000_3000, 5'd0, 1'b1, 1'b0);
    progIn(3, 3'd4, 64'h0000_0001_0010_0000, 5'd0, 1'b1, 1'b1);
    look(1'b1, 64'h10, 3'd0);
    check("R8 bar0 addr", lkAddrOut, 64'h8000_0010);
    look(1'b1, 64'h1FFC, 3'd1);
    check("R8 bar1 addr", lkAddrOut, 64'h8000_3FFC);
    look(1'b1, 64'h10, 3'd2); check("R8 no bar-match no hit", 64'(lkHit), 64'h0);
    look(1'b1, 64'hABCD, 3'd4);
    check("R8 bar4 64-bit target", lkAddrOut, 64'h1_0010_ABCD);
    check("R8 bar4 region", 64'(lkRegion), 64'h3);
    look(1'b1, 64'h10, 3'd5); check("R8 unused bar miss", 64'(lkHit), 64'h0);
    look(1'b0, 64'h1_0000_1900, 0);
    check("R2 inbound writes leave outbound", 64'(lkRegion), 64'h0);

    // Random outbound windows against the model (R4 R5 R6 R7)
    for (int it = 0; it < 250; it++) begin
      int r;
      logic [31:0] bLo, sz, hi;
      r = int'($urandom % 4);
      bLo = $urandom_range(32'h7000_0000, 32'h1000);
      sz = $urandom_range(32'h2_0000, 32'h1);
      hi = $urandom % 3;
      progOut(r, hi, bLo, bLo + sz - 1, $urandom, $urandom, 5'($urandom % 6), 1'($urandom % 4 != 0));
      for (int k = 0; k < 16; k++) begin
        logic [63:0] a;
        int pick;
        pick = int'($urandom % 4);
        a[63:32] = ($urandom % 4 == 0) ? $urandom % 3 : mBaseHi[pick];
        a[31:0] = mBaseLo[pick] + ($urandom % (mLimit[pick] - mBaseLo[pick] + 9)) - 4;
        look(1'b0, a, 0);
        expectOut(a, eh, eo, et, er);
        check("R4 random hit", 64'(lkHit), 64'(eh));
        check("R4 random addr", lkAddrOut, eo);
        check("R6 random type", 64'(lkType), 64'(et));
        if (eh) check("R6 random region", 64'(lkRegion), 64'(er));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule